// File: doc/BRIEF.md
# Data-Strobe Serial Receiver with Pair Regrouping

This block takes a serial line made of a data wire and a strobe wire and turns it into a stream of two-bit words in the local system-clock domain. Exactly one of the two wires changes for every bit, so the XOR of the two is a bit clock that toggles once per bit. The block captures each bit on that recovered clock and pairs consecutive bits. Each pair then crosses into the system-clock domain through a small dual-clock FIFO. The system clock runs at half the bit rate, so a steady stream delivers one pair per system cycle.

The output is a valid/ready stream. A pair is presented while `pair_valid` is high. It is consumed on a rising clock edge where both `pair_valid` and `pair_ready` are high. While `pair_ready` is low the presented pair holds and the FIFO absorbs the incoming pairs. A pair that arrives while the FIFO holds DEPTH unread pairs is dropped, so a stalled consumer loses only the newest data.

A packet may end on an odd bit. After the line has been quiet for a set number of cycles, a quiet detector discards the pending bit. It also re-arms the pairing logic, so that the next packet starts a fresh pair whatever level the wires were left at.

Top module: `ds_strobe_rx`

## Requirements
- R1: Every change of `line_d XOR line_s` marks exactly one received bit, and the value of that bit is the level of `line_d` just after the change.
- R2: Bits are paired in arrival order: the earlier bit of a pair appears on `pair_data[1]` and the later bit on `pair_data[0]`.
- R3: While `pair_valid` is high and `pair_ready` is low, `pair_valid` stays high and `pair_data` stays unchanged on the next cycle. Each handshake removes exactly one pair.
- R4: After reset the FIFO accepts DEPTH pairs (default 8) with `pair_ready` held low. Later pairs are dropped until space is freed, and the pairs that were kept come out in order.
- R5: After the line has kept the recovered-clock level high (an odd bit pending) with no pair activity for QUIET_CYC system cycles (default 8), the pending bit is discarded and never delivered. The next bit received starts a new pair.
- R6: Reset empties the FIFO and clears the pairing phase. `pair_valid` is low during reset and stays low until two bits of one pair have been received, so a lone bit never raises it.
- R7: With `pair_ready` held high, a continuous bit stream at twice the system clock rate is delivered complete, with no pair lost or repeated.
- R8: The number of unread pairs seen from the read side never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock, half the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_d | input | 1 | Serial data wire, asynchronous |
| line_s | input | 1 | Serial strobe wire, asynchronous |
| pair_valid | output | 1 | A received pair is presented |
| pair_ready | input | 1 | Consumer accepts the presented pair |
| pair_data | output | 2 | Pair, earlier bit in bit 1 |

## Verification
On every system cycle the embedded properties check four things: the read-side occupancy bound, that a stalled pair holds, that a pop advances by exactly one entry, and that the quiet detector only flushes with an odd bit pending and then flips its polarity. Bit decoding, pair order, discarding a trailing odd bit and re-alignment for the next packet can only be shown by the bench. It sweeps every bit pattern of lengths one to eight through the line encoding and compares the delivered pairs with pairs computed from the pattern. The drop policy at a full FIFO, the lone-bit case after reset and sustained full-rate delivery are likewise shown only by directed bench scenarios.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  typedef logic [1:0] pair_t;

  typedef enum logic [1:0] {
    QS_WATCH = 2'd0,
    QS_FLUSH = 2'd1,
    QS_DONE  = 2'd2
  } qstate_e;
endpackage

// File: rtl/ds_sync2.sv
// Two-flop synchroniser for a bus whose value changes by at most one bit
// (Gray pointer) or for independent single-bit levels.
module ds_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ds_pair_capture.sv
// Runs on the recovered bit clock. The rising edge holds the first bit of a
// pair; the falling edge presents the pair to the FIFO write port.
module ds_pair_capture
  import ds_rx_pkg::*;
(
  input  logic  bclk,
  input  logic  clr_x,
  input  logic  line_d,
  output logic  wr_req,
  output pair_t wr_pair,
  output logic  activity
);
  logic first_bit;
  logic hold_tog;
  logic take_tog;

  // rising edge: a new first bit is pending
  always_ff @(posedge bclk or posedge clr_x) begin
    if (clr_x) begin
      first_bit <= 1'b0;
      hold_tog  <= 1'b0;
    end else begin
      first_bit <= line_d;
      hold_tog  <= ~take_tog;
    end
  end

  // falling edge: the pending first bit is consumed
  always_ff @(negedge bclk or posedge clr_x) begin
    if (clr_x) take_tog <= 1'b0;
    else       take_tog <= hold_tog;
  end

  assign wr_req   = hold_tog ^ take_tog;
  assign wr_pair  = {first_bit, line_d};
  assign activity = hold_tog;
endmodule

// File: rtl/ds_async_fifo.sv
// Dual-clock FIFO of bit pairs. Writes happen on the falling edge of the
// recovered clock, reads in the system clock domain. Gray pointers cross.
module ds_async_fifo
  import ds_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  wr_clk,
  input  logic  rst_n,
  input  logic  wr_req,
  input  pair_t wr_data,
  input  logic  rd_clk,
  output logic  rd_valid,
  input  logic  rd_ready,
  output pair_t rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  pair_t mem [DEPTH];

  // ---------------- write side ----------------
  logic [PW-1:0] wbin, wgray, wbin_nx;
  logic [PW-1:0] rq_meta, rq_sync;
  logic          full;

  assign wbin_nx = wbin + 1'b1;
  assign full    = (wgray == {~rq_sync[PW-1:PW-2], rq_sync[PW-3:0]});

  always_ff @(negedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_meta <= '0;
      rq_sync <= '0;
    end else begin
      rq_meta <= rgray;
      rq_sync <= rq_meta;
    end
  end

  always_ff @(negedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_req && !full) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(negedge wr_clk) begin
    if (wr_req && !full) mem[wbin[AW-1:0]] <= wr_data;
  end

  // ---------------- read side ----------------
  logic [PW-1:0] rbin, rgray, rbin_nx, wq, wq_bin;
  logic          pop;

  ds_sync2 #(.W(PW)) u_wsync (
    .clk  (rd_clk),
    .rst_n(rst_n),
    .d    (wgray),
    .q    (wq)
  );

  assign wq_bin   = gray2bin(wq);
  assign rd_valid = (rgray != wq);
  assign rd_data  = mem[rbin[AW-1:0]];
  assign pop      = rd_valid && rd_ready;
  assign rbin_nx  = rbin + 1'b1;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  // occupancy seen by the reader never exceeds the storage (R8, R4)
  p_occupancy_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (PW'(wq_bin - rbin) <= PW'(DEPTH)));

  // a stalled pair is held (R3)
  p_stall_hold_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // one handshake removes exactly one entry (R3)
  p_pop_step_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (rbin == PW'($past(rbin) + 1'b1)));
endmodule

// File: rtl/ds_quiet_align.sv
// System-domain watcher: when the recovered clock has stayed high (an odd
// bit pending) with no pair activity for QUIET_CYC cycles, it clears the
// capture stage and flips the line polarity so the next bit starts a pair.
module ds_quiet_align
  import ds_rx_pkg::*;
#(
  parameter int QUIET_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_lvl,
  input  logic activity,
  output logic flush,
  output logic pol
);
  localparam int CW = $clog2(QUIET_CYC + 1);

  logic [1:0]  s_q;
  logic        ex_s, act_s, act_q;
  logic [CW-1:0] cnt;
  qstate_e     st;

  ds_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bclk_lvl, activity}),
    .q    (s_q)
  );

  assign ex_s  = s_q[1];
  assign act_s = s_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= QS_WATCH;
      cnt   <= '0;
      flush <= 1'b0;
      pol   <= 1'b0;
      act_q <= 1'b0;
    end else begin
      act_q <= act_s;
      unique case (st)
        QS_WATCH: begin
          if (!ex_s || (act_s != act_q)) begin
            cnt <= '0;
          end else if (cnt == CW'(QUIET_CYC - 1)) begin
            cnt   <= '0;
            flush <= 1'b1;
            st    <= QS_FLUSH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        QS_FLUSH: begin
          pol <= ~pol;
          st  <= QS_DONE;
        end
        QS_DONE: begin
          flush <= 1'b0;
          cnt   <= '0;
          st    <= QS_WATCH;
        end
        default: st <= QS_WATCH;
      endcase
    end
  end

  // flush only follows a high recovered-clock level (R5)
  p_flush_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> $past(ex_s));

  // the polarity flips while the capture stage is still held clear (R5)
  p_flush_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |=> (flush && (pol != $past(pol))));
endmodule

// File: rtl/ds_strobe_rx.sv
module ds_strobe_rx
  import ds_rx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int QUIET_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_d,
  input  logic       line_s,
  output logic       pair_valid,
  input  logic       pair_ready,
  output logic [1:0] pair_data
);
  logic  bclk, pol, flush, clr_x;
  logic  wr_req, activity;
  pair_t wr_pair, rd_pair;

  // recovered bit clock, re-based so an idle line always sits low
  assign bclk  = line_d ^ line_s ^ pol;
  assign clr_x = flush | ~rst_n;

  ds_pair_capture u_cap (
    .bclk    (bclk),
    .clr_x   (clr_x),
    .line_d  (line_d),
    .wr_req  (wr_req),
    .wr_pair (wr_pair),
    .activity(activity)
  );

  ds_async_fifo #(.DEPTH(DEPTH)) u_fifo (
    .wr_clk  (bclk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_data (wr_pair),
    .rd_clk  (clk),
    .rd_valid(pair_valid),
    .rd_ready(pair_ready),
    .rd_data (rd_pair)
  );

  ds_quiet_align #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_lvl(bclk),
    .activity(activity),
    .flush   (flush),
    .pol     (pol)
  );

  assign pair_data = rd_pair;
endmodule

// File: tb/sim_ds_strobe_rx.sv
module sim_ds_strobe_rx;
  localparam int CLK_PERIOD = 20;
  localparam int BIT_NS     = CLK_PERIOD / 2;
  localparam int DEPTH      = 8;
  localparam int QUIET      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_d = 1'b0;
  logic       line_s = 1'b0;
  logic       rdy = 1'b1;
  logic       pair_valid;
  logic [1:0] pair_data;

  int n_cmp = 0;
  int n_bad = 0;
  int got[$];
  int exp_q[$];

  ds_strobe_rx #(.DEPTH(DEPTH), .QUIET_CYC(QUIET)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_d    (line_d),
    .line_s    (line_s),
    .pair_valid(pair_valid),
    .pair_ready(rdy),
    .pair_data (pair_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && pair_valid && rdy) got.push_back(int'(pair_data));
  end

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // data-strobe encoding: data carries the bit, strobe toggles when data repeats
  task automatic send_bit(input logic b);
    if (b != line_d) line_d = b;
    else             line_s = ~line_s;
    #(BIT_NS);
  endtask

  task automatic send_packet(input int len, input logic [63:0] bits);
    @(posedge clk);
    #3;
    for (int k = 0; k < len; k++) begin
      send_bit(bits[k]);
      if (k % 2 == 1) exp_q.push_back({bits[k-1], bits[k]});
    end
  endtask

  task automatic settle_compare(input string req);
    repeat (4 * QUIET) @(posedge clk);
    check({req, " pair count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++)
      check({req, " pair value"}, (i < got.size()) ? got[i] : -1, exp_q[i]);
    got.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #5;
    check("R6 valid low in reset", int'(pair_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    got.delete();
    exp_q.delete();
    repeat (4 * QUIET) @(posedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] pat;
    logic [15:0] lfsr;
    do_reset();
    #5;
    check("R6 valid low after reset", int'(pair_valid), 0);

    // R6: one lone bit never raises valid
    send_packet(1, 64'h1);
    repeat (3) @(posedge clk);
    #5;
    check("R6 lone bit no valid", int'(pair_valid), 0);
    settle_compare("R6");

    // R1 R2 R5: every pattern of length 1..8; odd tails are discarded
    for (int len = 1; len <= 8; len++) begin
      for (int p = 0; p < (1 << len); p++) begin
        pat = 64'(p);
        send_packet(len, pat);
        settle_compare((len % 2 == 1) ? "R5 R1 R2 odd" : "R1 R2 even");
      end
    end

    // R7: long continuous stream at full rate
    lfsr = 16'hACE1;
    for (int k = 0; k < 64; k++) begin
      pat[k] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    send_packet(64, pat);
    settle_compare("R7 stream");

    // R3 R4: stall from reset, overfill, then drain
    do_reset();
    rdy = 1'b0;
    for (int k = 0; k < 20; k++) pat[k] = ((k * 7 + 3) % 5) > 1;
    send_packet(20, pat);
    repeat (6) @(posedge clk);
    #5;
    check("R3 valid while stalled", int'(pair_valid), 1);
    check("R3 first pair shown", int'(pair_data), int'({pat[0], pat[1]}));
    repeat (5) @(posedge clk);
    #5;
    check("R3 pair held", int'(pair_data), int'({pat[0], pat[1]}));
    // only DEPTH pairs were kept (R4)
    while (exp_q.size() > DEPTH) void'(exp_q.pop_back());
    rdy = 1'b1;
    settle_compare("R4 drop when full");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule